// File: doc/BRIEF.md
# Extended-Precision Floating-Point Multiplier

This block multiplies two 48-bit floating-point operands and returns a 48-bit product. Each operand has an 8-bit two's-complement exponent and a 40-bit two's-complement fraction. The fraction's binary point sits just below its sign bit. Each value is carried as three 16-bit words. The high word holds fraction bits 39..24. The middle word holds fraction bits 23..16 above the exponent. The low word holds fraction bits 15..0.

A one-cycle `start` pulse launches an operation. The block first adds the exponents and checks the sum. An out-of-range sum produces a saturated or zero result at once, with no multiply. Otherwise a shift-add engine forms the signed fraction product over one cycle per fraction bit. The product is then corrected for the minus-one-squared case, normalized and range-checked. The result, the overflow and underflow flags and a 4-bit condition code are registered, and `done` pulses for a single cycle. A surrounding core copies the result into its register file and latches the flags into its fault logic.

Top module: `fpx_ext_mul`

## Requirements
- R1: A value is packed as {fraction[39:16], exponent[7:0], fraction[15:0]} on a 48-bit port, for operands and result alike.
- R2: If the sum of the operand exponents is 127 or greater, the result is exponent 0x7F with fraction 0x7FFFFFFFFF when the two operand fraction sign bits match, or 0x8000000000 when they differ, and `ovf` is raised. A sum of 126 does not trigger this.
- R3: If the exponent sum is below -128, the result is all zero and `unf` is raised. A sum of exactly -128 does not trigger this.
- R4: Otherwise, the fractions are multiplied as signed integers and the product is shifted left by one bit. The upper 40 bits are kept with lower bits truncated (no rounding). The result is normalized by shifting left and decrementing the exponent until fraction bits 39 and 38 differ.
- R5: When the kept fraction is 0x8000000000 (minus one times minus one), it becomes 0x4000000000 and the exponent is incremented.
- R6: If that increment brings the exponent to 127 or more, the result saturates as in R2, with the sign taken from the corrected fraction's top bit, and `ovf` is raised.
- R7: If normalization takes the exponent below -128, the result is all zero and `unf` is raised.
- R8: A zero product fraction, including one that truncates to zero, gives an all-zero result with neither flag raised.
- R9: `cond` is 4'b0010 for an all-zero result, 4'b0001 for a negative fraction and 4'b0100 for a positive nonzero result.
- R10: `done` is high for exactly one cycle per accepted operation. `ovf` and `unf` are high only during that cycle.
- R11: A `start` that arrives between acceptance and the cycle after `done` is ignored and produces no extra `done`.
- R12: During reset, `done`, `ovf`, `unf`, `result` and `cond` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch pulse, taken only when idle |
| op_a | input | 48 | First operand, packed per R1 |
| op_b | input | 48 | Second operand, packed per R1 |
| done | output | 1 | One-cycle completion strobe |
| result | output | 48 | Packed product, held until the next completion |
| ovf | output | 1 | Overflow flag, valid with done |
| unf | output | 1 | Underflow flag, valid with done |
| cond | output | 4 | Condition code of the result |

## Verification
A fault in the working exponent register or the correction path shows up in the exponent field of the very next `done`. Such faults often show as a missed or spurious saturation on cases built around the 126/127 and -128/-129 borders. A multiplier engine that stops early or late, or picks the wrong product slice, corrupts the fraction of that same result. Truncation cases whose correct product is zero or one LSB make even a single-bit slip visible. A sequencer that re-accepts `start` while busy reveals itself by an extra `done` within one multiply length.

// File: rtl/fpx_pkg.sv
// Shared widths, state type and packing helpers for the extended-precision
// multiplier. Assumes the fraction is wider than 16 bits.
package fpx_pkg;
    localparam int MANT_W = 40;
    localparam int EXP_W  = 8;
    localparam int FP_W   = MANT_W + EXP_W;

    typedef enum logic [1:0] {ST_IDLE, ST_MUL, ST_DONE} fpx_state_e;

    // Extract the fraction from a packed value
    function automatic logic [MANT_W-1:0] fpx_mant(input logic [FP_W-1:0] v);
        return {v[FP_W-1:EXP_W+16], v[15:0]};
    endfunction

    // Extract the exponent from a packed value
    function automatic logic [EXP_W-1:0] fpx_exp(input logic [FP_W-1:0] v);
        return v[EXP_W+15:16];
    endfunction

    // Build a packed value from fraction and exponent
    function automatic logic [FP_W-1:0] fpx_pack(input logic [MANT_W-1:0] m,
                                                 input logic [EXP_W-1:0] e);
        return {m[MANT_W-1:16], e, m[15:0]};
    endfunction

    // Condition code: zero / negative / positive
    function automatic logic [3:0] fpx_cc(input logic [FP_W-1:0] v);
        if (v == '0)          return 4'b0010;
        else if (v[FP_W-1])   return 4'b0001;
        else                  return 4'b0100;
    endfunction
endpackage

// File: rtl/fpx_seq_mul.sv
// Signed shift-add multiplier. Multiplies magnitudes one bit per cycle and
// applies the sign at the output. Assumes load is only pulsed when idle;
// the product is held stable after valid until the next load.
module fpx_seq_mul #(
    parameter int W = 40
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] prod,
    output logic           valid
);
    localparam int CW = $clog2(W + 1);

    logic [2*W-1:0] mcand;
    logic [2*W-1:0] acc;
    logic [W-1:0]   mplier;
    logic [CW-1:0]  cnt;
    logic           neg;
    logic           run;

    // Load magnitudes on launch, then accumulate one partial product per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand  <= '0;
            acc    <= '0;
            mplier <= '0;
            cnt    <= '0;
            neg    <= 1'b0;
            run    <= 1'b0;
            valid  <= 1'b0;
        end else if (load) begin
            mcand  <= {{W{1'b0}}, (a[W-1] ? -a : a)};
            mplier <= b[W-1] ? -b : b;
            acc    <= '0;
            cnt    <= '0;
            neg    <= a[W-1] ^ b[W-1];
            run    <= 1'b1;
            valid  <= 1'b0;
        end else if (run) begin
            acc    <= acc + (mplier[0] ? mcand : '0);
            mcand  <= mcand << 1;
            mplier <= mplier >> 1;
            cnt    <= cnt + CW'(1);
            run    <= (cnt != CW'(W - 1));
            valid  <= (cnt == CW'(W - 1));
        end else begin
            valid  <= 1'b0;
        end
    end

    // Restore the product sign
    always_comb prod = neg ? -acc : acc;

    // R10
    mul_valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);
    // R4
    mul_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (mplier == '0));
endmodule

// File: rtl/fpx_norm.sv
// Single-cycle normalizer. Counts redundant sign bits below the top bit,
// shifts them out and lowers the exponent to match. Assumes a zero fraction
// is handled by the caller (its shift count is meaningless).
module fpx_norm #(
    parameter int W  = 40,
    parameter int XW = 10
) (
    input  logic [W-1:0]         m_in,
    input  logic signed [XW-1:0] n_in,
    output logic [W-1:0]         m_out,
    output logic signed [XW-1:0] n_out
);
    localparam int SW = $clog2(W);

    logic [SW-1:0] sh;
    logic          stop;

    // Count leading bits equal to the sign bit
    always_comb begin
        sh   = '0;
        stop = 1'b0;
        for (int i = W - 2; i >= 0; i--) begin
            if (!stop && (m_in[i] == m_in[W-1])) sh = sh + SW'(1);
            else                                 stop = 1'b1;
        end
    end

    // Apply the shift to fraction and exponent
    always_comb begin
        m_out = m_in << sh;
        n_out = n_in - XW'(sh);
    end
endmodule

// File: rtl/fpx_ext_mul.sv
// Extended-precision floating-point multiply: exponent range pre-check,
// sequential fraction multiply, minus-one-squared correction, normalization,
// saturation and condition code. Assumes start is a single-cycle request;
// requests are taken only when idle.
module fpx_ext_mul
    import fpx_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [FP_W-1:0] op_a,
    input  logic [FP_W-1:0] op_b,
    output logic            done,
    output logic [FP_W-1:0] result,
    output logic            ovf,
    output logic            unf,
    output logic [3:0]      cond
);
    localparam int XW = EXP_W + 2;
    localparam logic signed [XW-1:0] EMAX = XW'((1 << (EXP_W - 1)) - 1);
    localparam logic signed [XW-1:0] EMIN = XW'(-(1 << (EXP_W - 1)));
    localparam logic [MANT_W-1:0] M_NEG1 = {1'b1, {(MANT_W-1){1'b0}}};
    localparam logic [MANT_W-1:0] M_HALF = {2'b01, {(MANT_W-2){1'b0}}};
    localparam logic [MANT_W-1:0] M_POSMAX = {1'b0, {(MANT_W-1){1'b1}}};
    localparam logic [EXP_W-1:0] E_SAT = EMAX[EXP_W-1:0];

    fpx_state_e state;
    logic signed [XW-1:0] n_q, n_sum, n_corr, n_norm;
    logic [MANT_W-1:0] ma, mb, m_kept, m_corr, m_norm;
    logic [2*MANT_W-1:0] prod;
    logic mul_valid, mul_load, early_ovf, early_unf;
    logic late_ovf, late_unf, is_corr;
    logic load_res;
    logic [FP_W-1:0] fin_res;
    logic fin_ovf, fin_unf;

    // Decode operands and form the working exponent sum
    always_comb begin
        ma        = fpx_mant(op_a);
        mb        = fpx_mant(op_b);
        n_sum     = XW'($signed(fpx_exp(op_a))) + XW'($signed(fpx_exp(op_b)));
        early_ovf = (n_sum >= EMAX);
        early_unf = (n_sum < EMIN);
        mul_load  = (state == ST_IDLE) && start && !early_ovf && !early_unf;
    end

    fpx_seq_mul #(.W(MANT_W)) u_mul (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (mul_load),
        .a     (ma),
        .b     (mb),
        .prod  (prod),
        .valid (mul_valid)
    );

    // Take the shifted product slice and correct the minus-one-squared case
    always_comb begin
        m_kept   = prod[2*MANT_W-2:MANT_W-1];
        is_corr  = (m_kept == M_NEG1);
        m_corr   = is_corr ? M_HALF : m_kept;
        n_corr   = is_corr ? n_q + XW'(1) : n_q;
        late_ovf = (n_corr >= EMAX);
    end

    fpx_norm #(.W(MANT_W), .XW(XW)) u_norm (
        .m_in  (m_corr),
        .n_in  (n_corr),
        .m_out (m_norm),
        .n_out (n_norm)
    );

    // Select the final packed result for whichever path completes
    always_comb begin
        late_unf = (m_corr != '0) && (n_norm < EMIN);
        fin_ovf  = 1'b0;
        fin_unf  = 1'b0;
        fin_res  = '0;
        load_res = 1'b0;
        if (state == ST_IDLE && start && early_ovf) begin
            load_res = 1'b1;
            fin_ovf  = 1'b1;
            fin_res  = fpx_pack((ma[MANT_W-1] ^ mb[MANT_W-1]) ? M_NEG1 : M_POSMAX, E_SAT);
        end else if (state == ST_IDLE && start && early_unf) begin
            load_res = 1'b1;
            fin_unf  = 1'b1;
        end else if (state == ST_MUL && mul_valid) begin
            load_res = 1'b1;
            if (late_ovf) begin
                fin_ovf = 1'b1;
                fin_res = fpx_pack(m_corr[MANT_W-1] ? M_NEG1 : M_POSMAX, E_SAT);
            end else if (late_unf) begin
                fin_unf = 1'b1;
            end else if (m_corr != '0) begin
                fin_res = fpx_pack(m_norm, n_norm[EXP_W-1:0]);
            end
        end
    end

    // Sequencer: idle -> multiply -> done, or idle -> done on a range fault
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            n_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    n_q   <= n_sum;
                    state <= (early_ovf || early_unf) ? ST_DONE : ST_MUL;
                end
                ST_MUL:  if (mul_valid) state <= ST_DONE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Result registers; flags live only for the done cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            cond   <= '0;
            ovf    <= 1'b0;
            unf    <= 1'b0;
        end else if (load_res) begin
            result <= fin_res;
            cond   <= fpx_cc(fin_res);
            ovf    <= fin_ovf;
            unf    <= fin_unf;
        end else begin
            ovf    <= 1'b0;
            unf    <= 1'b0;
        end
    end

    // Completion strobe
    always_comb done = (state == ST_DONE);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10
    flag_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf || unf) |-> done);
    // R2
    ovf_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (fpx_exp(result) == E_SAT));
    // R7
    unf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unf |-> (result == '0));
    // R9
    cc_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($countones(cond) == 1));
    // R4
    norm_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result != '0) |-> (result[FP_W-1] != result[FP_W-2]));
    // R11
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MUL) |=> $stable(n_q));
    // R3
    no_both_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf && unf));
endmodule

// File: tb/fpx_ext_mul_tb.sv
module fpx_ext_mul_tb;
    import fpx_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [47:0] op_a = '0, op_b = '0;
    logic done, ovf, unf;
    logic [47:0] result;
    logic [3:0] cond;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;   // 250 MHz

    fpx_ext_mul u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
        .done(done), .result(result), .ovf(ovf), .unf(unf), .cond(cond)
    );

    typedef struct packed {
        logic [39:0] am; logic [7:0] ae;
        logic [39:0] bm; logic [7:0] be;
        logic [39:0] rm; logic [7:0] re;
        logic ov; logic un; logic [3:0] cc; logic [7:0] req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        // R4: 0.5 x 0.5 -> normalized 0.5, exp -1
        '{40'h4000000000, 8'h00, 40'h4000000000, 8'h00, 40'h4000000000, 8'hFF, 1'b0, 1'b0, 4'b0100, 8'd4},
        // R4: negative product normalizes to -1
        '{40'h4000000000, 8'h03, 40'hC000000000, 8'h02, 40'h8000000000, 8'h03, 1'b0, 1'b0, 4'b0001, 8'd4},
        // R4: 0.75 x 0.75 already normalized
        '{40'h6000000000, 8'h01, 40'h6000000000, 8'h01, 40'h4800000000, 8'h02, 1'b0, 1'b0, 4'b0100, 8'd4},
        // R5: -1 x -1 corrected
        '{40'h8000000000, 8'h04, 40'h8000000000, 8'h05, 40'h4000000000, 8'h0A, 1'b0, 1'b0, 4'b0100, 8'd5},
        // R6: correction pushes exponent to 127
        '{40'h8000000000, 8'h3F, 40'h8000000000, 8'h3F, 40'h7FFFFFFFFF, 8'h7F, 1'b1, 1'b0, 4'b0100, 8'd6},
        // R2: early overflow, signs differ
        '{40'h4000000000, 8'h64, 40'hC000000000, 8'h1B, 40'h8000000000, 8'h7F, 1'b1, 1'b0, 4'b0001, 8'd2},
        // R2: early overflow, signs equal
        '{40'hC000000000, 8'h7F, 40'hC000000000, 8'h00, 40'h7FFFFFFFFF, 8'h7F, 1'b1, 1'b0, 4'b0100, 8'd2},
        // R3: sum -129 underflows early
        '{40'h4000000000, 8'h9C, 40'h4000000000, 8'hE3, 40'h0, 8'h00, 1'b0, 1'b1, 4'b0010, 8'd3},
        // R7: sum -128, normalization underflows
        '{40'h4000000000, 8'hC0, 40'h4000000000, 8'hC0, 40'h0, 8'h00, 1'b0, 1'b1, 4'b0010, 8'd7},
        // R3: sum -128 exactly, no underflow
        '{40'h6000000000, 8'hC0, 40'h6000000000, 8'hC0, 40'h4800000000, 8'h80, 1'b0, 1'b0, 4'b0100, 8'd3},
        // R2: sum 126, no overflow
        '{40'h4000000000, 8'h3F, 40'h6000000000, 8'h3F, 40'h6000000000, 8'h7D, 1'b0, 1'b0, 4'b0100, 8'd2},
        // R8: zero operand
        '{40'h0000000000, 8'h05, 40'h4000000000, 8'h03, 40'h0, 8'h00, 1'b0, 1'b0, 4'b0010, 8'd8},
        // R4: truncation floors minus one LSB times 0.5
        '{40'hFFFFFFFFFF, 8'h00, 40'h4000000000, 8'h00, 40'h8000000000, 8'hD9, 1'b0, 1'b0, 4'b0001, 8'd4},
        // R8: positive product truncates to zero
        '{40'h0000000001, 8'h00, 40'h4000000000, 8'h00, 40'h0, 8'h00, 1'b0, 1'b0, 4'b0010, 8'd8}
    };

    // R1: packing used for every operand and expectation
    function automatic logic [47:0] pk(input logic [39:0] m, input logic [7:0] e);
        return {m[39:16], e, m[15:0]};
    endfunction

    task automatic check(input bit ok, input string req, input logic [47:0] act,
                         input logic [47:0] exp_v);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
        end
    endtask

    task automatic run_op(input logic [47:0] a, input logic [47:0] b, output bit got);
        @(negedge clk);
        op_a = a; op_b = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        got = 1'b0;
        for (int k = 0; k < 100 && !got; k++) begin
            if (done) got = 1'b1;
            else @(negedge clk);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 48'h0, 48'h1);
        finish_run();
    end

    initial begin
        bit got;
        int extra;
        logic [47:0] first_res;
        repeat (3) @(negedge clk);
        // R12: reset state
        check(!done && !ovf && !unf, "R12", {45'h0, done, ovf, unf}, 48'h0);
        check(result == '0 && cond == '0, "R12", result, 48'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
            run_op(pk(VECS[i].am, VECS[i].ae), pk(VECS[i].bm, VECS[i].be), got);
            check(got, tag, {47'h0, got}, 48'h1);
            check(result == pk(VECS[i].rm, VECS[i].re), tag, result, pk(VECS[i].rm, VECS[i].re));
            check(ovf == VECS[i].ov && unf == VECS[i].un, tag,
                  {46'h0, ovf, unf}, {46'h0, VECS[i].ov, VECS[i].un});
            // R9: condition code
            check(cond == VECS[i].cc, "R9", {44'h0, cond}, {44'h0, VECS[i].cc});
            @(negedge clk);
            // R10: single-cycle done and flags
            check(!done && !ovf && !unf, "R10", {45'h0, done, ovf, unf}, 48'h0);
        end

        // R11: start while busy is ignored
        @(negedge clk);
        op_a = pk(40'h6000000000, 8'h01); op_b = pk(40'h6000000000, 8'h01); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        op_a = pk(40'h4000000000, 8'h00); op_b = pk(40'h4000000000, 8'h00); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        got = 1'b0;
        for (int k = 0; k < 100 && !got; k++) begin
            if (done) got = 1'b1;
            else @(negedge clk);
        end
        first_res = result;
        check(got && first_res == pk(40'h4800000000, 8'h02), "R11", first_res,
              pk(40'h4800000000, 8'h02));
        extra = 0;
        for (int k = 0; k < 80; k++) begin
            @(negedge clk);
            if (done) extra++;
        end
        check(extra == 0, "R11", 48'(extra), 48'h0);
        check(result == first_res, "R11", result, first_res);

        finish_run();
    end
endmodule